// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Controller

This block is the digital half of a successive-approximation converter. It holds a small control and configuration register set. It divides the system clock down to a conversion clock and steps each conversion through sampling, a most-significant-bit-first binary search and a short finishing phase. It then latches the result and raises an end-of-conversion interrupt request. The analog comparator is outside the block. The block presents a trial code on `sar_trial_o`, and the comparator answers on `cmp_i`: 1 means the input is at or above the trial code.

Software starts a conversion by writing the start bit, or arms auto-triggering so that a rising edge on one selected line of `trig_i` starts each conversion. The first conversion after reset also runs an initialization phase and so takes longer. The register port has a combinational read and a single-cycle write.

Register map: address 0 is CTRL, with start at bit 0, auto-trigger enable at bit 1, done flag at bit 2, interrupt enable at bit 3 and high-speed at bit 4. Address 1 is CFG, with the prescaler code at bits [2:0] and the trigger select at bits [6:3]. Address 2 holds result bits [7:0] and address 3 holds result bits [9:8] in its bits [1:0]. All addresses are read-only except CTRL and CFG.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every readable field at addresses 0 to 3 reads 0, and `irq_o` and `hs_mode_o` are 0.
- R2: Writing 1 to CTRL bit 0 starts a conversion, and CTRL bit 0 reads 1 while it runs. Hardware clears the bit when the conversion completes. Writing 0 to it while a conversion runs does not stop or restart the conversion.
- R3: A normal conversion lasts 13 conversion-clock periods. The done flag becomes visible exactly 13 × divisor system clocks after the clock edge that accepted the start.
- R4: The first conversion after reset lasts 25 conversion-clock periods, which is 25 × divisor system clocks.
- R5: CTRL bit 2 (the done flag) is set on the same edge that the result registers are updated.
- R6: The done flag clears when `irq_ack_i` is high for one cycle, or when software writes 1 to CTRL bit 2. Writing 0 to CTRL bit 2 leaves the flag set.
- R7: `irq_o` is 1 only when both the done flag and CTRL bit 3 (interrupt enable) are 1.
- R8: CFG bits [2:0] select the conversion-clock divisor. Codes 0 to 7 give divisors 2, 2, 4, 8, 16, 32, 64 and 128.
- R9: With CTRL bit 1 set, a rising edge on `trig_i[CFG[6:3]]` starts a conversion, and edges on the other lines do nothing. With CTRL bit 1 clear, edges on `trig_i` start nothing.
- R10: A trigger edge that arrives while a conversion is running does not start another conversion.
- R11: The result is built by binary search, MSB first: a trial bit is kept when `cmp_i` is 1. With a comparator that answers `input >= sar_trial_o`, the result equals the input code.
- R12: CTRL bit 4 drives `hs_mode_o` and reads back.
- R13: The result registers hold their value until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| trig_i | input | 16 | Auto-trigger source lines |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| sar_trial_o | output | 10 | Trial code for the comparator reference |
| sample_o | output | 1 | High during the sampling period |
| hs_mode_o | output | 1 | High-speed mode select for the analog part |
| irq_o | output | 1 | End-of-conversion interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the done flag |

## Verification
The bench builds the block with its defaults: a 10-bit result, 16 trigger lines, a 3-bit prescaler code, 12 initialization clocks and 2 finishing clocks. Because the initialization length is 12, the first-conversion length of 25 periods can be told apart from the normal 13. Because the prescaler code is 3 bits, every divisor from 2 to 128 is reachable, including the special case of code 0. With 16 trigger lines, the bench can pulse lines that are not selected next to the selected line 5.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_CFG    = 2'd1;
  localparam logic [1:0] ADDR_RES_LO = 2'd2;
  localparam logic [1:0] ADDR_RES_HI = 2'd3;

  localparam int BIT_START = 0;
  localparam int BIT_AUTO  = 1;
  localparam int BIT_FLAG  = 2;
  localparam int BIT_IE    = 3;
  localparam int BIT_HS    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SAMPLE,
    ST_CONV,
    ST_FINISH
  } seq_state_e;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int PRESC_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  localparam int CNT_W = (1 << PRESC_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;

  // divisor 2^code, except code 0 which also divides by 2
  always_comb begin
    if (presc == '0) limit = CNT_W'(1);
    else             limit = CNT_W'((32'd1 << presc) - 32'd1);
  end

  assign tick = run && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int NUM_TRIG = 16,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]    sel,
  output logic                edge_o
);
  logic [NUM_TRIG-1:0] prev_q;
  logic [NUM_TRIG-1:0] rise;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_edge
    assign rise[g] = trig_i[g] & ~prev_q[g];
  end

  assign edge_o = (32'(sel) < NUM_TRIG) ? rise[sel] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= trig_i;
  end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int INIT_CLKS   = 12,
  parameter int FINISH_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             first,
  input  logic             tick,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sample_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o
);
  localparam int PH_W  = $clog2(INIT_CLKS + FINISH_CLKS + 1);
  localparam int IDX_W = $clog2(RES_W);

  seq_state_e       state_q, state_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [RES_W-1:0] sar_q, sar_d;
  logic [RES_W-1:0] res_q, res_d;
  logic [RES_W-1:0] bit_mask;
  logic             done;

  assign bit_mask = {{(RES_W-1){1'b0}}, 1'b1} << idx_q;
  assign done     = (state_q == ST_FINISH) && tick &&
                    (ph_q == PH_W'(FINISH_CLKS - 1));

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    idx_d   = idx_q;
    sar_d   = sar_q;
    res_d   = res_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = first ? ST_INIT : ST_SAMPLE;
          ph_d    = '0;
          sar_d   = '0;
        end
      end
      ST_INIT: begin
        if (tick) begin
          if (ph_q == PH_W'(INIT_CLKS - 1)) begin
            state_d = ST_SAMPLE;
            ph_d    = '0;
          end else begin
            ph_d = ph_q + PH_W'(1);
          end
        end
      end
      ST_SAMPLE: begin
        if (tick) begin
          state_d = ST_CONV;
          idx_d   = IDX_W'(RES_W - 1);
        end
      end
      ST_CONV: begin
        if (tick) begin
          if (cmp_i) sar_d = sar_q | bit_mask;
          if (idx_q == '0) begin
            state_d = ST_FINISH;
            ph_d    = '0;
          end else begin
            idx_d = idx_q - IDX_W'(1);
          end
        end
      end
      ST_FINISH: begin
        if (tick) begin
          if (done) begin
            state_d = ST_IDLE;
            res_d   = sar_q;
          end else begin
            ph_d = ph_q + PH_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      idx_q   <= '0;
      sar_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      idx_q   <= idx_d;
      sar_q   <= sar_d;
      res_q   <= res_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done;
  assign sample_o = (state_q == ST_SAMPLE);
  assign trial_o  = (state_q == ST_CONV) ? (sar_q | bit_mask) : sar_q;
  assign result_o = res_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int NUM_TRIG    = 16,
  parameter int TSEL_W      = 4,
  parameter int PRESC_W     = 3,
  parameter int INIT_CLKS   = 12,
  parameter int FINISH_CLKS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic                cmp_i,
  output logic [RES_W-1:0]    sar_trial_o,
  output logic                sample_o,
  output logic                hs_mode_o,
  output logic                irq_o,
  input  logic                irq_ack_i
);
  localparam int RES_PAD = 16 - RES_W;

  logic              rst_meta_q, rst_sync_n;
  logic              auto_q, auto_d;
  logic              ie_q, ie_d;
  logic              hs_q, hs_d;
  logic              flag_q, flag_d;
  logic              init_done_q, init_done_d;
  logic [PRESC_W-1:0] presc_q, presc_d;
  logic [TSEL_W-1:0]  tsel_q, tsel_d;
  logic              ctrl_wr, cfg_wr;
  logic              trig_edge, start_req;
  logic              tick, busy, done;
  logic [RES_W-1:0]  result;
  logic [15:0]       res_ext;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign ctrl_wr = reg_we && (reg_addr == ADDR_CTRL);
  assign cfg_wr  = reg_we && (reg_addr == ADDR_CFG);

  adc_trig_sel #(
    .NUM_TRIG (NUM_TRIG),
    .SEL_W    (TSEL_W)
  ) u_trig (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .trig_i (trig_i),
    .sel    (tsel_q),
    .edge_o (trig_edge)
  );

  assign start_req = !busy &&
                     ((ctrl_wr && reg_wdata[BIT_START]) || (auto_q && trig_edge));

  adc_clk_div #(
    .PRESC_W (PRESC_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (busy),
    .presc (presc_q),
    .tick  (tick)
  );

  adc_sar_seq #(
    .RES_W       (RES_W),
    .INIT_CLKS   (INIT_CLKS),
    .FINISH_CLKS (FINISH_CLKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start_req),
    .first    (!init_done_q),
    .tick     (tick),
    .cmp_i    (cmp_i),
    .busy_o   (busy),
    .done_o   (done),
    .sample_o (sample_o),
    .trial_o  (sar_trial_o),
    .result_o (result)
  );

  always_comb begin
    auto_d      = auto_q;
    ie_d        = ie_q;
    hs_d        = hs_q;
    presc_d     = presc_q;
    tsel_d      = tsel_q;
    flag_d      = flag_q;
    init_done_d = init_done_q | done;
    if (ctrl_wr) begin
      auto_d = reg_wdata[BIT_AUTO];
      ie_d   = reg_wdata[BIT_IE];
      hs_d   = reg_wdata[BIT_HS];
    end
    if (cfg_wr) begin
      presc_d = reg_wdata[PRESC_W-1:0];
      tsel_d  = reg_wdata[PRESC_W +: TSEL_W];
    end
    if (done)                                          flag_d = 1'b1;
    else if (irq_ack_i || (ctrl_wr && reg_wdata[BIT_FLAG])) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      auto_q      <= 1'b0;
      ie_q        <= 1'b0;
      hs_q        <= 1'b0;
      presc_q     <= '0;
      tsel_q      <= '0;
      flag_q      <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      auto_q      <= auto_d;
      ie_q        <= ie_d;
      hs_q        <= hs_d;
      presc_q     <= presc_d;
      tsel_q      <= tsel_d;
      flag_q      <= flag_d;
      init_done_q <= init_done_d;
    end
  end

  assign res_ext = {{RES_PAD{1'b0}}, result};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[BIT_START] = busy;
        reg_rdata[BIT_AUTO]  = auto_q;
        reg_rdata[BIT_FLAG]  = flag_q;
        reg_rdata[BIT_IE]    = ie_q;
        reg_rdata[BIT_HS]    = hs_q;
      end
      ADDR_CFG:    reg_rdata[PRESC_W+TSEL_W-1:0] = {tsel_q, presc_q};
      ADDR_RES_LO: reg_rdata = res_ext[7:0];
      default:     reg_rdata = res_ext[15:8];
    endcase
  end

  assign hs_mode_o = hs_q;
  assign irq_o     = flag_q & ie_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             flag,
  input logic             ie,
  input logic             irq,
  input logic             ack,
  input logic             we,
  input logic [1:0]       addr,
  input logic [7:0]       wdata,
  input logic [RES_W-1:0] result
);
  AST_FLAG_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $fell(busy)); // R5

  AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done)); // R2

  AST_WRITE_ZERO_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && we && addr == 2'd0 && !wdata[0]) |=> busy); // R2

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && flag)); // R7

  AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !done) |=> !flag); // R6

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result)); // R13
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .busy   (busy),
  .done   (done),
  .flag   (flag_q),
  .ie     (ie_q),
  .irq    (irq_o),
  .ack    (irq_ack_i),
  .we     (reg_we),
  .addr   (reg_addr),
  .wdata  (reg_wdata),
  .result (result)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic [15:0] trig_i = 16'd0;
  logic        cmp_i;
  logic [9:0]  sar_trial_o;
  logic        sample_o, hs_mode_o, irq_o;
  logic        irq_ack_i = 1'b0;
  logic [9:0]  analog = 10'd0;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // comparator model: input at or above the trial code
  assign cmp_i = (analog >= sar_trial_o);

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_i(trig_i),
    .cmp_i(cmp_i), .sar_trial_o(sar_trial_o), .sample_o(sample_o),
    .hs_mode_o(hs_mode_o), .irq_o(irq_o), .irq_ack_i(irq_ack_i)
  );

  // {first, prescaler code, input code}
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 3'd0, 10'h2A5},
    {1'b0, 3'd1, 10'h3FF},
    {1'b0, 3'd2, 10'h000},
    {1'b0, 3'd3, 10'h155},
    {1'b0, 3'd7, 10'h200},
    {1'b0, 3'd5, 10'h1FF}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic wait_flag(output int n);
    logic [7:0] v;
    n = 0;
    rd(2'd0, v);
    while (!v[2] && n < 20000) begin
      @(negedge clk);
      n++;
      rd(2'd0, v);
    end
  endtask

  task automatic read_result(output int r);
    logic [7:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    r = {hi[1:0], lo};
  endtask

  task automatic pulse_trig(input int line);
    @(negedge clk);
    trig_i = 16'(1) << line;
    @(negedge clk);
    trig_i = 16'd0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n, r, div, exp_n, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 8'd0, "R1", v, 0);
    end
    check(!irq_o && !hs_mode_o, "R1", {irq_o, hs_mode_o}, 0);

    // table walk: R2 R3 R4 R5 R8 R11
    for (int i = 0; i < NV; i++) begin
      analog = VEC[i][9:0];
      div = (VEC[i][12:10] == 3'd0) ? 2 : (1 << VEC[i][12:10]);
      exp_n = (VEC[i][13] ? 25 : 13) * div;
      wr(2'd1, {5'd0, VEC[i][12:10]});
      wr(2'd0, 8'h01);
      rd(2'd0, v);
      check(v[0], "R2", v[0], 1);
      wait_flag(n);
      check(n == exp_n, VEC[i][13] ? "R4" : "R3/R8", n, exp_n);
      rd(2'd0, v);
      check(!v[0], "R2", v[0], 0);
      read_result(r);
      check(r == int'(VEC[i][9:0]), "R5/R11", r, VEC[i][9:0]);
      wr(2'd0, 8'h04);
      rd(2'd0, v);
      check(!v[2], "R6", v[2], 0);
    end

    // R2: writing 0 to start while busy has no effect
    analog = 10'h0F0;
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h01);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h00);
    rd(2'd0, v);
    check(v[0], "R2", v[0], 1);
    wait_flag(n);
    read_result(r);
    check(r == 10'h0F0, "R2", r, 10'h0F0);
    wr(2'd0, 8'h04);

    // R9: auto trigger on selected line 5, div 2
    analog = 10'h321;
    wr(2'd1, 8'h29);
    wr(2'd0, 8'h02);
    pulse_trig(3);
    rd(2'd0, v);
    check(!v[0], "R9", v[0], 0);
    pulse_trig(5);
    rd(2'd0, v);
    check(v[0], "R9", v[0], 1);
    // R10: second edge while running is ignored
    repeat (3) @(negedge clk);
    pulse_trig(5);
    wait_flag(n);
    repeat (6) @(negedge clk);
    rd(2'd0, v);
    check(!v[0], "R10", v[0], 0);
    read_result(r);
    check(r == 10'h321, "R9", r, 10'h321);

    // R7: flag set, enable clear -> no request
    check(!irq_o, "R7", irq_o, 0);
    // enable interrupt, write 0 to flag: flag stays (R6), request rises (R7)
    wr(2'd0, 8'h08);
    rd(2'd0, v);
    check(v[2], "R6", v[2], 1);
    check(irq_o, "R7", irq_o, 1);
    @(negedge clk); irq_ack_i = 1'b1;
    @(negedge clk); irq_ack_i = 1'b0;
    rd(2'd0, v);
    check(!v[2] && !irq_o, "R6", {v[2], irq_o}, 0);

    // R9: auto trigger off -> edge ignored
    wr(2'd0, 8'h00);
    pulse_trig(5);
    rd(2'd0, v);
    check(!v[0], "R9", v[0], 0);

    // R12: high-speed bit
    wr(2'd0, 8'h10);
    rd(2'd0, v);
    check(hs_mode_o && v[4], "R12", {hs_mode_o, v[4]}, 3);

    // R13: result holds while no conversion completes
    prev = 10'h321;
    analog = 10'h055;
    repeat (60) @(negedge clk);
    read_result(r);
    check(r == prev, "R13", r, prev);

    finish_run();
  end
endmodule